// File: doc/BRIEF.md
# ECC Error Status and Log Capture

This block sits beside a memory controller and records DRAM ECC events from up to two channels. Each channel presents a one-cycle event pulse with a correctable or an uncorrectable flag, together with the column, row, bank, rank and syndrome of the failing access. The block keeps a two-flag error status register and one 64-bit error log per channel. Software polls and clears them over a simple 32-bit register bus.

A log captures the first error that reaches it while it is empty. An uncorrectable error may displace a correctable entry, but nothing displaces an uncorrectable entry. Clearing a status flag re-arms every log that carries that kind of error. The 64-bit logs are reached as two aligned 32-bit words. Reading the low word takes a snapshot of the high word, so a two-step read stays coherent. A strap input selects single-channel operation, in which only channel 0 is live.

Top module: `ecc_err_regs`

## Requirements
- R1: After reset the status register, both log words of every channel and `reg_rdata` read as zero.
- R2: The status register at address 0x0010 reads bit 0 as the correctable flag and bit 1 as the uncorrectable flag; bits 31:2 read zero. A correctable event on an active channel sets bit 0. An uncorrectable event on an active channel sets bit 1.
- R3: A write to the status register with a data bit at 1 clears the matching flag. A data bit at 0 leaves its flag unchanged.
- R4: The channel 0 log low word is at 0x2000 and its high word at 0x2004. Each further channel sits 0x400 higher. The low word holds bank [31:29], rank [28:27], syndrome [23:16], uncorrectable status [1] and correctable status [0]. The high word holds column [31:16] and row [15:0]. Read data appears on `reg_rdata` at the clock edge that samples `reg_rd`.
- R5: A correctable event captures its fields into an empty log and sets the log's correctable bit. A correctable event reaching a log that already holds any error changes no log field.
- R6: An uncorrectable event reaching a log that holds a correctable error, or no error, replaces all fields. It sets the uncorrectable bit, clears the correctable bit and stores syndrome 0.
- R7: While a log holds an uncorrectable error, later events of either kind leave it unchanged.
- R8: Clearing a status flag also clears the matching status bit in every channel log. The log fields stay readable, and the log then accepts a new capture.
- R9: An event that lands in the same cycle as a clear of its flag wins. The flag stays set and the log captures the new event.
- R10: A read of a log's low word latches that log's high word. A read of the high word returns the value latched at the most recent low-word read of the same channel.
- R11: When `dual_chan` is 0, events on channel 1 are ignored and the channel 1 log words read as zero.
- R12: Accesses with address bits [1:0] not zero, writes to the log addresses and reads of unmapped addresses have no effect; such reads return zero.
- R13: A correctable and an uncorrectable flag raised together on one channel count as an uncorrectable event only. Status bit 0 is not set by that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dual_chan | input | 1 | Strap: 1 enables channel 1, 0 means single-channel mode |
| ev_ce | input | NCH | Per-channel correctable error pulse |
| ev_ue | input | NCH | Per-channel uncorrectable error pulse |
| ev_col | input | NCH x 16 | Per-channel error column |
| ev_row | input | NCH x 16 | Per-channel error row |
| ev_bank | input | NCH x 3 | Per-channel error bank |
| ev_rank | input | NCH x 2 | Per-channel error rank |
| ev_syn | input | NCH x 8 | Per-channel error syndrome |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |

## Verification
An event pulse is sampled at one rising edge and is visible in the status register and logs from the next cycle. A read strobe is sampled at a rising edge and its data is on `reg_rdata` right after that edge. The bench drives every input at a falling edge. Each read pushes its expected word into a queue. A monitor notes each sampled read strobe at the rising edge, then pops and compares at the following falling edge, so every comparison lands exactly one edge after the read it belongs to. The same-cycle collision of an event and a clear is driven inside a single bus cycle. The high-word snapshot is checked by placing an overwriting event between the low and high reads.

// File: rtl/ecc_err_regs.sv
module ecc_err_regs #(
  parameter int NCH = 2,
  parameter int AW = 16,
  parameter logic [AW-1:0] STATUS_ADDR = 16'h0010,
  parameter logic [AW-1:0] LOG_BASE = 16'h2000,
  parameter logic [AW-1:0] CH_STRIDE = 16'h0400
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  dual_chan,
  input  logic [NCH-1:0]        ev_ce,
  input  logic [NCH-1:0]        ev_ue,
  input  logic [NCH-1:0][15:0]  ev_col,
  input  logic [NCH-1:0][15:0]  ev_row,
  input  logic [NCH-1:0][2:0]   ev_bank,
  input  logic [NCH-1:0][1:0]   ev_rank,
  input  logic [NCH-1:0][7:0]   ev_syn,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [AW-1:0]         reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata
);

  logic st_ce, st_ue;
  logic [NCH-1:0] ce_q, ue_q, act, a_ce, a_ue;
  logic [NCH-1:0][15:0] row_q;
  logic [NCH-1:0][31:0] rd_part;
  logic [31:0] rd_val;
  logic unused_wdata;

  wire aligned = (reg_addr[1:0] == 2'b00);
  wire st_wr   = reg_wr & aligned & (reg_addr == STATUS_ADDR);
  wire clr_ce  = st_wr & reg_wdata[0];
  wire clr_ue  = st_wr & reg_wdata[1];

  assign unused_wdata = ^reg_wdata[31:2];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [AW-1:0] LO_A = LOG_BASE + AW'(c * int'(CH_STRIDE));
    localparam logic [AW-1:0] HI_A = LO_A + AW'(4);

    logic ce_r, ue_r;
    logic [15:0] col_r, row_r;
    logic [2:0] bank_r;
    logic [1:0] rank_r;
    logic [7:0] syn_r;
    logic [31:0] snap_r;
    logic ue_hold, ce_hold, cap_ue, cap_ce, lo_rd, hi_rd;

    if (c == 0) begin : g_act0
      assign act[c] = 1'b1;
    end else begin : g_actn
      assign act[c] = dual_chan;
    end

    assign a_ue[c] = act[c] & ev_ue[c];
    assign a_ce[c] = act[c] & ev_ce[c] & ~ev_ue[c];

    assign ue_hold = ue_r & ~clr_ue;
    assign ce_hold = ce_r & ~clr_ce;
    assign cap_ue  = a_ue[c] & ~ue_hold;
    assign cap_ce  = a_ce[c] & ~ue_hold & ~ce_hold;

    assign lo_rd = reg_rd & aligned & act[c] & (reg_addr == LO_A);
    assign hi_rd = aligned & act[c] & (reg_addr == HI_A);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ce_r   <= 1'b0;
        ue_r   <= 1'b0;
        col_r  <= '0;
        row_r  <= '0;
        bank_r <= '0;
        rank_r <= '0;
        syn_r  <= '0;
        snap_r <= '0;
      end else begin
        ue_r <= ue_hold | cap_ue;
        ce_r <= ~cap_ue & (ce_hold | cap_ce);
        if (cap_ue | cap_ce) begin
          col_r  <= ev_col[c];
          row_r  <= ev_row[c];
          bank_r <= ev_bank[c];
          rank_r <= ev_rank[c];
          syn_r  <= cap_ue ? 8'h00 : ev_syn[c];
        end
        if (lo_rd) snap_r <= {col_r, row_r};
      end
    end

    assign ce_q[c]  = ce_r;
    assign ue_q[c]  = ue_r;
    assign row_q[c] = row_r;

    assign rd_part[c] = (aligned & act[c] & (reg_addr == LO_A)) ?
                          {bank_r, rank_r, 3'b000, syn_r, 14'b0, ue_r, ce_r} :
                        hi_rd ? snap_r : 32'h0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_ce <= 1'b0;
      st_ue <= 1'b0;
    end else begin
      st_ce <= (|a_ce) | (st_ce & ~clr_ce);
      st_ue <= (|a_ue) | (st_ue & ~clr_ue);
    end
  end

  always_comb begin
    rd_val = (aligned && reg_addr == STATUS_ADDR) ? {30'b0, st_ue, st_ce} : 32'h0;
    for (int c = 0; c < NCH; c++) rd_val = rd_val | rd_part[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else        reg_rdata <= reg_rd ? rd_val : 32'h0;
  end

endmodule

// File: rtl/ecc_err_regs_chk.sv
module ecc_err_regs_chk #(
  parameter int NCH = 2,
  parameter int AW = 16,
  parameter logic [AW-1:0] STATUS_ADDR = 16'h0010
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 dual_chan,
  input logic [NCH-1:0]       ev_ce,
  input logic [NCH-1:0]       ev_ue,
  input logic                 reg_wr,
  input logic [AW-1:0]        reg_addr,
  input logic [1:0]           wbits,
  input logic                 st_ce,
  input logic                 st_ue,
  input logic [NCH-1:0]       ce_q,
  input logic [NCH-1:0]       ue_q,
  input logic [NCH-1:0][15:0] row_q
);

  logic [NCH-1:0] live;
  wire wr_st = reg_wr && (reg_addr == STATUS_ADDR);
  wire k_ce  = wr_st && wbits[0];
  wire k_ue  = wr_st && wbits[1];

  for (genvar c = 0; c < NCH; c++) begin : g_c
    assign live[c] = (c == 0) ? 1'b1 : dual_chan;

    a_r7_ue_held: assert property (@(posedge clk) disable iff (!rst_n)
      ue_q[c] && !k_ue |=> ue_q[c] && $stable(row_q[c]));

    a_r6_ue_takes: assert property (@(posedge clk) disable iff (!rst_n)
      live[c] && ev_ue[c] |=> ue_q[c] && !ce_q[c]);

    a_r5_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
      !(ce_q[c] && ue_q[c]));

    a_r5_ce_first: assert property (@(posedge clk) disable iff (!rst_n)
      live[c] && ev_ce[c] && !ev_ue[c] && !ue_q[c] |=> ce_q[c]);

    if (c > 0) begin : g_single
      a_r11_idle_ch: assert property (@(posedge clk) disable iff (!rst_n)
        !dual_chan && !ce_q[c] && !ue_q[c] |=> !ce_q[c] && !ue_q[c]);
    end
  end

  a_r9_ue_wins: assert property (@(posedge clk) disable iff (!rst_n)
    |(ev_ue & live) |=> st_ue);

  a_r3_ce_kept: assert property (@(posedge clk) disable iff (!rst_n)
    st_ce && !k_ce |=> st_ce);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !st_ue && !(|(ev_ue & live)) |=> !st_ue);

endmodule

bind ecc_err_regs ecc_err_regs_chk #(.NCH(NCH), .AW(AW), .STATUS_ADDR(STATUS_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .dual_chan(dual_chan), .ev_ce(ev_ce), .ev_ue(ev_ue),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .wbits(reg_wdata[1:0]),
  .st_ce(st_ce), .st_ue(st_ue), .ce_q(ce_q), .ue_q(ue_q), .row_q(row_q)
);

// File: tb/ecc_err_regs_bench.sv
`timescale 1ns/1ps
module ecc_err_regs_bench;
  localparam logic [15:0] ST = 16'h0010, L0 = 16'h2000, L1 = 16'h2400;

  logic clk = 0, rst_n = 0, dual_chan = 1;
  logic [1:0] ev_ce = 0, ev_ue = 0;
  logic [1:0][15:0] ev_col = '0, ev_row = '0;
  logic [1:0][2:0] ev_bank = '0;
  logic [1:0][1:0] ev_rank = '0;
  logic [1:0][7:0] ev_syn = '0;
  logic reg_wr = 0, reg_rd = 0;
  logic [15:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;

  int n_run = 0, n_fail = 0;
  bit done = 0, rd_seen = 0;
  logic [31:0] q_exp[$];
  string q_tag[$];

  always #10 clk = ~clk;

  ecc_err_regs u_ecc_err_regs (.*);

  always @(posedge clk) rd_seen <= reg_rd;

  always @(negedge clk) if (rd_seen) begin
    logic [31:0] e;
    string t;
    e = q_exp.pop_front();
    t = q_tag.pop_front();
    n_run++;
    if (reg_rdata !== e) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", t, reg_rdata, e);
    end
  end

  function automatic logic [31:0] mk(logic [2:0] b, logic [1:0] r, logic [7:0] s, logic u, logic c);
    return {b, r, 3'b000, s, 14'b0, u, c};
  endfunction

  task automatic rd(input logic [15:0] a, input logic [31:0] e, input string t);
    q_exp.push_back(e);
    q_tag.push_back(t);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic pulse(input logic [1:0] ce, input logic [1:0] ue, input logic wr,
                       input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    ev_ce = ce; ev_ue = ue; reg_wr = wr; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    ev_ce = 0; ev_ue = 0; reg_wr = 0;
  endtask

  task automatic fld(input int ch, input logic [15:0] col, input logic [15:0] row,
                     input logic [2:0] b, input logic [1:0] r, input logic [7:0] s);
    ev_col[ch] = col; ev_row[ch] = row; ev_bank[ch] = b; ev_rank[ch] = r; ev_syn[ch] = s;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(ST, 0, "R1 status after reset");
    rd(L0, 0, "R1 log0 low after reset");
    rd(L0 + 4, 0, "R1 log0 high after reset");

    fld(0, 16'h1234, 16'h5678, 3'd5, 2'd2, 8'hA5);
    pulse(2'b01, 0, 0, 0, 0);
    rd(ST, 32'h1, "R2 status after correctable");
    rd(L0, mk(5, 2, 8'hA5, 0, 1), "R4 R5 log0 low after correctable");
    rd(L0 + 4, 32'h12345678, "R4 log0 high after correctable");

    fld(0, 16'h9999, 16'h8888, 3'd1, 2'd1, 8'h11);
    pulse(2'b01, 0, 0, 0, 0);
    rd(L0, mk(5, 2, 8'hA5, 0, 1), "R5 second correctable ignored low");
    rd(L0 + 4, 32'h12345678, "R5 second correctable ignored high");

    fld(0, 16'hAAAA, 16'hBBBB, 3'd3, 2'd1, 8'hFF);
    pulse(0, 2'b01, 0, 0, 0);
    rd(ST, 32'h3, "R2 status after uncorrectable");
    rd(L0, mk(3, 1, 8'h00, 1, 0), "R6 overwrite low");
    rd(L0 + 4, 32'hAAAABBBB, "R6 overwrite high");

    fld(0, 16'h0101, 16'h0202, 3'd7, 2'd3, 8'h33);
    pulse(2'b01, 0, 0, 0, 0);
    pulse(0, 2'b01, 0, 0, 0);
    rd(L0, mk(3, 1, 8'h00, 1, 0), "R7 held low");
    rd(L0 + 4, 32'hAAAABBBB, "R7 held high");

    pulse(0, 0, 1, ST, 32'h0);
    rd(ST, 32'h3, "R3 zero write keeps flags");
    pulse(0, 0, 1, L0, 32'hFFFFFFFF);
    rd(L0, mk(3, 1, 8'h00, 1, 0), "R12 log write ignored");
    pulse(0, 0, 1, ST + 1, 32'h3);
    rd(ST, 32'h3, "R12 misaligned write ignored");
    rd(L0 + 1, 0, "R12 misaligned read zero");
    rd(16'h0100, 0, "R12 unmapped read zero");

    pulse(0, 0, 1, ST, 32'h2);
    rd(ST, 32'h1, "R3 clear uncorrectable only");
    rd(L0, mk(3, 1, 8'h00, 0, 0), "R8 log bit cleared fields kept");
    pulse(0, 0, 1, ST, 32'h1);
    rd(ST, 32'h0, "R3 clear correctable");

    fld(0, 16'h0C0C, 16'h0D0D, 3'd2, 2'd0, 8'h5A);
    pulse(2'b01, 0, 0, 0, 0);
    rd(L0, mk(2, 0, 8'h5A, 0, 1), "R8 re-armed capture");

    fld(0, 16'h0E0E, 16'h0F0F, 3'd6, 2'd3, 8'hC3);
    pulse(2'b01, 0, 1, ST, 32'h1);
    rd(ST, 32'h1, "R9 event beats clear status");
    rd(L0, mk(6, 3, 8'hC3, 0, 1), "R9 event beats clear log");

    pulse(0, 0, 1, ST, 32'h3);
    fld(0, 16'h4444, 16'h5555, 3'd4, 2'd2, 8'h77);
    pulse(2'b01, 2'b01, 0, 0, 0);
    rd(ST, 32'h2, "R13 joint flags status");
    rd(L0, mk(4, 2, 8'h00, 1, 0), "R13 joint flags log");

    pulse(0, 0, 1, ST, 32'h3);
    fld(1, 16'h1111, 16'h2222, 3'd1, 2'd3, 8'h3C);
    pulse(2'b10, 0, 0, 0, 0);
    rd(L1, mk(1, 3, 8'h3C, 0, 1), "R4 channel1 low");
    fld(1, 16'h3333, 16'h4444, 3'd2, 2'd1, 8'h00);
    pulse(0, 2'b10, 0, 0, 0);
    rd(L1 + 4, 32'h11112222, "R10 high word snapshot");
    rd(L1, mk(2, 1, 8'h00, 1, 0), "R10 fresh low");
    rd(L1 + 4, 32'h33334444, "R10 fresh high");
    rd(L0, mk(4, 2, 8'h00, 0, 0), "R4 channel0 untouched by channel1");

    pulse(0, 0, 1, ST, 32'h3);
    dual_chan = 0;
    fld(1, 16'h7777, 16'h6666, 3'd5, 2'd1, 8'h99);
    pulse(2'b10, 0, 0, 0, 0);
    pulse(0, 2'b10, 0, 0, 0);
    rd(ST, 32'h0, "R11 channel1 ignored status");
    rd(L1, 0, "R11 channel1 reads zero");
    dual_chan = 1;
    rd(L1, mk(2, 1, 8'h00, 0, 0), "R11 channel1 not captured");

    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule